// File: doc/BRIEF.md
# Direct-Addressing Instruction Sequencer

This block is a compact 8-bit processor core. It carries out a small set of instructions that take a one-byte direct operand. Each instruction runs as a fixed chain of bus cycles, and each cycle is exactly one clock. In every cycle the core drives a 16-bit address, a read/write line and a bus-valid strobe toward an external memory. The memory returns read data within the same cycle and captures write data on the closing clock edge.

The core holds a 16-bit accumulator D, whose upper and lower bytes also serve as accumulators A and B. It also holds two 16-bit index registers X and Y and a 16-bit program counter. Three instructions are supported:
- load A direct
- store Y direct, which is encoded with a prefix byte
- add to D direct

Any other byte stops the core with a sticky fault flag. A debug port exposes PC, A, B, X and Y. The reset values of PC, D, X and Y come from parameters.

Top module: `dirseq_top`

## Requirements
- R1: `bus_rw` is 1 in every read cycle and 0 in every write cycle, and `bus_rw` is 0 only while `bus_valid` is 1.
- R2: Every instruction byte, including a prefix byte, is read from the address in PC. PC advances by exactly one after each such byte and changes in no other way. When an instruction completes, PC holds the address of the following instruction.
- R3: While `rst` is high and after its release, PC, `bus_addr` and `dbg_pc` equal the START_ADDR parameter. D, X and Y take D_INIT, X_INIT and Y_INIT, `illegal` is 0, and the first cycle after release is an opcode fetch at START_ADDR.
- R4: Byte 0x96 loads A in 3 cycles: opcode read at PC, operand byte dd read at PC+1, then a read at 0x00dd whose data is written into A. B is left unchanged.
- R5: Bytes 0x18, 0xDF, dd store Y in 5 cycles: three instruction-byte reads, then a write of Y[15:8] to 0x00dd, then a write of Y[7:0] to 0x00dd+1.
- R6: Byte 0xD3 adds to D in 5 cycles: opcode read, dd read, a read of the high operand byte at 0x00dd, a read of the low operand byte at 0x00dd+1, then one cycle with no memory transfer. At the end of that last cycle D becomes D + operand.
- R7: Operand and data cycles drive the computed address (dd zero-extended, and its 16-bit increment, so dd=0xFF gives 0x0100) instead of PC, and PC does not change during them.
- R8: The add is modulo 2^16. The carry out of bit 15 is dropped.
- R9: `dbg_a` always equals D[15:8] and `dbg_b` always equals D[7:0].
- R10: A first byte other than 0x96, 0xD3 or 0x18 sets `illegal`. From the next cycle on, `bus_valid` stays 0 and PC stays at the address of the offending byte until reset.
- R11: A byte other than 0xDF after the prefix 0x18 has the same effect as R10, with PC left at the address of that second byte.
- R12: In every cycle without a memory transfer (the add's last cycle and halted cycles), `bus_valid` is 0 and `bus_rw` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | output | 16 | Address of the current bus cycle (registered) |
| bus_rw | output | 1 | 1 = read or no transfer, 0 = write (registered) |
| bus_valid | output | 1 | 1 when the cycle transfers data (registered) |
| bus_wdata | output | 8 | Write data, meaningful when bus_rw is 0 (registered) |
| bus_rdata | input | 8 | Read data returned by memory within the cycle |
| illegal | output | 1 | Sticky fault flag for an unrecognised byte |
| dbg_pc | output | 16 | Program counter |
| dbg_a | output | 8 | Accumulator A (D high byte) |
| dbg_b | output | 8 | Accumulator B (D low byte) |
| dbg_x | output | 16 | Index register X |
| dbg_y | output | 16 | Index register Y |

## Verification
The properties assume that `rst` is held high for at least one rising edge before the first checked cycle. They also assume that `bus_rdata` is a defined value whenever a read cycle is in progress. The bench satisfies both conditions. It keeps reset asserted for several cycles before every program. Its memory model returns zero for any address outside the populated page and code window, so every read returns a defined byte. All program images sit in the code window at the start address, and all operand addresses fall in the zero page or just past it.

// File: rtl/dirseq_pkg.sv
package dirseq_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  localparam logic [BYTE_W-1:0] OPC_LOAD_A = 8'h96;
  localparam logic [BYTE_W-1:0] OPC_ADD_D  = 8'hD3;
  localparam logic [BYTE_W-1:0] OPC_PREFIX = 8'h18;
  localparam logic [BYTE_W-1:0] OPC_STOR_Y = 8'hDF;

  typedef enum logic [3:0] {
    ST_OPC,
    ST_PFX,
    ST_DIR,
    ST_LDA,
    ST_WHI,
    ST_WLO,
    ST_RHI,
    ST_RLO,
    ST_ALU,
    ST_HALT
  } state_t;

  typedef enum logic [1:0] {
    K_NONE,
    K_LDA,
    K_STY,
    K_ADD
  } kind_t;

endpackage

// File: rtl/dirseq_decode.sv
module dirseq_decode
  import dirseq_pkg::*;
(
  input  logic [BYTE_W-1:0] code_byte,
  input  logic              after_pfx,
  output kind_t             kind,
  output logic              is_pfx,
  output logic              bad
);

  always_comb begin
    kind   = K_NONE;
    is_pfx = 1'b0;
    if (after_pfx) begin
      if (code_byte == OPC_STOR_Y) kind = K_STY;
    end else begin
      case (code_byte)
        OPC_LOAD_A: kind   = K_LDA;
        OPC_ADD_D:  kind   = K_ADD;
        OPC_PREFIX: is_pfx = 1'b1;
        default:    kind   = K_NONE;
      endcase
    end
    bad = (kind == K_NONE) && !is_pfx;
  end

endmodule

// File: rtl/dirseq_add.sv
module dirseq_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);

  logic [W:0] full;

  assign full = {1'b0, a} + {1'b0, b};
  assign sum  = full[W-1:0];

endmodule

// File: rtl/dirseq_top.sv
module dirseq_top
  import dirseq_pkg::*;
#(
  parameter int                         ADDR_W     = 16,
  parameter logic [ADDR_W-1:0]          START_ADDR = 16'hF800,
  parameter logic [2*BYTE_W-1:0]        D_INIT     = '0,
  parameter logic [2*BYTE_W-1:0]        X_INIT     = '0,
  parameter logic [2*BYTE_W-1:0]        Y_INIT     = '0
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rw,
  output logic              bus_valid,
  output logic [BYTE_W-1:0] bus_wdata,
  input  logic [BYTE_W-1:0] bus_rdata,
  output logic              illegal,
  output logic [ADDR_W-1:0] dbg_pc,
  output logic [BYTE_W-1:0] dbg_a,
  output logic [BYTE_W-1:0] dbg_b,
  output logic [WORD_W-1:0] dbg_x,
  output logic [WORD_W-1:0] dbg_y
);

  localparam int PAD_W = ADDR_W - BYTE_W;

  // architectural state
  state_t              state_q, state_n;
  kind_t               kind_q, kind_n;
  logic [ADDR_W-1:0]   pc_q, pc_n;
  logic [ADDR_W-1:0]   ea_q, ea_n;
  logic [BYTE_W-1:0]   hi_q, hi_n, lo_q, lo_n;
  logic [WORD_W-1:0]   d_q, d_n;
  logic [WORD_W-1:0]   x_q, y_q;
  logic                ill_q, ill_n;

  // registered bus for the next cycle
  logic [ADDR_W-1:0]   addr_q, addr_n;
  logic                rw_q, rw_n;
  logic                valid_q, valid_n;
  logic [BYTE_W-1:0]   wdata_q, wdata_n;

  // datapath helpers
  logic [ADDR_W-1:0]   pc_inc, ea_inc, dd_addr;
  logic [WORD_W-1:0]   d_sum;
  kind_t               dec_kind;
  logic                dec_pfx, dec_bad;

  assign dd_addr = {{PAD_W{1'b0}}, bus_rdata};

  dirseq_decode u_dec (
    .code_byte (bus_rdata),
    .after_pfx (state_q == ST_PFX),
    .kind      (dec_kind),
    .is_pfx    (dec_pfx),
    .bad       (dec_bad)
  );

  dirseq_add #(.W(ADDR_W)) u_pc_inc (
    .a   (pc_q),
    .b   (ADDR_W'(1)),
    .sum (pc_inc)
  );

  dirseq_add #(.W(ADDR_W)) u_ea_inc (
    .a   (ea_q),
    .b   (ADDR_W'(1)),
    .sum (ea_inc)
  );

  dirseq_add #(.W(WORD_W)) u_alu (
    .a   (d_q),
    .b   ({hi_q, lo_q}),
    .sum (d_sum)
  );

  always_comb begin
    state_n = state_q;
    kind_n  = kind_q;
    pc_n    = pc_q;
    ea_n    = ea_q;
    hi_n    = hi_q;
    lo_n    = lo_q;
    d_n     = d_q;
    ill_n   = ill_q;
    addr_n  = addr_q;
    rw_n    = 1'b1;
    valid_n = 1'b1;
    wdata_n = wdata_q;

    case (state_q)
      ST_OPC, ST_PFX: begin
        if (dec_bad) begin
          state_n = ST_HALT;
          ill_n   = 1'b1;
          valid_n = 1'b0;
        end else begin
          pc_n    = pc_inc;
          addr_n  = pc_inc;
          kind_n  = dec_kind;
          state_n = dec_pfx ? ST_PFX : ST_DIR;
        end
      end
      ST_DIR: begin
        pc_n   = pc_inc;
        ea_n   = dd_addr;
        addr_n = dd_addr;
        case (kind_q)
          K_LDA: state_n = ST_LDA;
          K_ADD: state_n = ST_RHI;
          K_STY: begin
            state_n = ST_WHI;
            rw_n    = 1'b0;
            wdata_n = y_q[WORD_W-1:BYTE_W];
          end
          default: begin
            state_n = ST_HALT;
            ill_n   = 1'b1;
            valid_n = 1'b0;
          end
        endcase
      end
      ST_LDA: begin
        d_n     = {bus_rdata, d_q[BYTE_W-1:0]};
        state_n = ST_OPC;
        addr_n  = pc_q;
      end
      ST_WHI: begin
        state_n = ST_WLO;
        addr_n  = ea_inc;
        rw_n    = 1'b0;
        wdata_n = y_q[BYTE_W-1:0];
      end
      ST_WLO: begin
        state_n = ST_OPC;
        addr_n  = pc_q;
      end
      ST_RHI: begin
        hi_n    = bus_rdata;
        state_n = ST_RLO;
        addr_n  = ea_inc;
      end
      ST_RLO: begin
        lo_n    = bus_rdata;
        state_n = ST_ALU;
        valid_n = 1'b0;
      end
      ST_ALU: begin
        d_n     = d_sum;
        state_n = ST_OPC;
        addr_n  = pc_q;
      end
      ST_HALT: begin
        valid_n = 1'b0;
      end
      default: begin
        state_n = ST_HALT;
        ill_n   = 1'b1;
        valid_n = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OPC;
      kind_q  <= K_NONE;
      pc_q    <= START_ADDR;
      ea_q    <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      d_q     <= D_INIT;
      x_q     <= X_INIT;
      y_q     <= Y_INIT;
      ill_q   <= 1'b0;
      addr_q  <= START_ADDR;
      rw_q    <= 1'b1;
      valid_q <= 1'b1;
      wdata_q <= '0;
    end else begin
      state_q <= state_n;
      kind_q  <= kind_n;
      pc_q    <= pc_n;
      ea_q    <= ea_n;
      hi_q    <= hi_n;
      lo_q    <= lo_n;
      d_q     <= d_n;
      ill_q   <= ill_n;
      addr_q  <= addr_n;
      rw_q    <= rw_n;
      valid_q <= valid_n;
      wdata_q <= wdata_n;
    end
  end

  assign bus_addr  = addr_q;
  assign bus_rw    = rw_q;
  assign bus_valid = valid_q;
  assign bus_wdata = wdata_q;
  assign illegal   = ill_q;
  assign dbg_pc    = pc_q;
  assign dbg_a     = d_q[WORD_W-1:BYTE_W];
  assign dbg_b     = d_q[BYTE_W-1:0];
  assign dbg_x     = x_q;
  assign dbg_y     = y_q;

endmodule

// File: rtl/dirseq_chk.sv
module dirseq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_rw,
  input logic              illegal,
  input logic [ADDR_W-1:0] dbg_pc
);

  logic armed = 1'b0;

  always_ff @(posedge clk) armed <= !rst;

  // R1: a write never happens outside a valid bus cycle
  p_write_qualified_r1: assert property (@(posedge clk) disable iff (rst)
    !bus_rw |-> bus_valid);

  // R2: PC only ever steps forward by one
  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst || !armed)
    (dbg_pc != $past(dbg_pc)) |-> (dbg_pc == $past(dbg_pc) + ADDR_W'(1)));

  // R12: a cycle without transfer keeps the line in read
  p_idle_reads_r12: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |-> bus_rw);

  // R10: the fault flag stays set
  p_illegal_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    illegal |=> illegal);

  // R10: a halted core issues no transfer
  p_halt_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !bus_valid);

  // R10: a halted core holds PC
  p_pc_frozen_r10: assert property (@(posedge clk) disable iff (rst || !armed)
    illegal |=> $stable(dbg_pc));

endmodule

bind dirseq_top dirseq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_valid (bus_valid),
  .bus_rw    (bus_rw),
  .illegal   (illegal),
  .dbg_pc    (dbg_pc)
);

// File: tb/test_dirseq_top.sv
module test_dirseq_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr;
  logic        bus_rw, bus_valid, illegal;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [15:0] dbg_pc, dbg_x, dbg_y;
  logic [7:0]  dbg_a, dbg_b;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dirseq_top #(
    .ADDR_W     (16),
    .START_ADDR (16'hF800),
    .D_INIT     (16'h0000),
    .X_INIT     (16'h1234),
    .Y_INIT     (16'h43BE)
  ) i_dirseq_top (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rw    (bus_rw),
    .bus_valid (bus_valid),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .illegal   (illegal),
    .dbg_pc    (dbg_pc),
    .dbg_a     (dbg_a),
    .dbg_b     (dbg_b),
    .dbg_x     (dbg_x),
    .dbg_y     (dbg_y)
  );

  // memory model: zero page plus one page of code at 0xF800
  logic [7:0] page_mem [0:511];
  logic [7:0] code_mem [0:255];

  always_comb begin
    if (bus_addr < 16'h0200)         bus_rdata = page_mem[bus_addr[8:0]];
    else if (bus_addr[15:8] == 8'hF8) bus_rdata = code_mem[bus_addr[7:0]];
    else                              bus_rdata = 8'h00;
  end

  always @(posedge clk)
    if (!rst && bus_valid && !bus_rw && bus_addr < 16'h0200)
      page_mem[bus_addr[8:0]] <= bus_wdata;

  // scoreboard
  typedef struct {
    bit          valid;
    bit          rw;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic [15:0] pc;
    bit          chk_d;
    logic [15:0] d;
    bit          ill;
    string       tag;
  } exp_t;

  exp_t q[$];

  task automatic push(bit v, bit rw, logic [15:0] a, logic [7:0] w,
                      logic [15:0] pc, bit cd, logic [15:0] d, bit ill, string tag);
    exp_t e;
    e.valid = v; e.rw = rw; e.addr = a; e.wdata = w; e.pc = pc;
    e.chk_d = cd; e.d = d; e.ill = ill; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic rd(logic [15:0] a, logic [15:0] pc, string tag);
    push(1, 1, a, 8'h00, pc, 0, 16'h0, 0, tag);
  endtask

  task automatic start(logic [15:0] pc, logic [15:0] d, string tag);
    push(1, 1, pc, 8'h00, pc, 1, d, 0, tag);
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] w, logic [15:0] pc, string tag);
    push(1, 0, a, w, pc, 0, 16'h0, 0, tag);
  endtask

  task automatic idle(logic [15:0] pc, bit ill, string tag);
    push(0, 1, 16'h0, 8'h00, pc, 0, 16'h0, ill, tag);
  endtask

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst && q.size() > 0) begin
        exp_t e;
        bit ok;
        e = q.pop_front();
        ok = (bus_valid == e.valid) && (bus_rw == e.rw) && (dbg_pc == e.pc) &&
             (illegal == e.ill) && (!e.valid || bus_addr == e.addr) &&
             (e.rw || bus_wdata == e.wdata) &&
             (!e.chk_d || {dbg_a, dbg_b} == e.d);
        n_run++;
        if (!ok) begin
          n_fail++;
          $display("FAIL %s actual v=%b rw=%b a=%h w=%h pc=%h d=%h ill=%b expected v=%b rw=%b a=%h w=%h pc=%h d=%h ill=%b",
                   e.tag, bus_valid, bus_rw, bus_addr, bus_wdata, dbg_pc, {dbg_a, dbg_b}, illegal,
                   e.valid, e.rw, e.addr, e.wdata, e.pc, e.d, e.ill);
        end
      end
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < 512; i++) page_mem[i] = 8'h00;
    for (int i = 0; i < 256; i++) code_mem[i] = 8'h00;
  endtask

  task automatic run_queue();
    @(negedge clk);
    rst = 1'b0;
    while (q.size() != 0) begin
      @(negedge clk);
      #2;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    #1;
    // R3: reset state
    check(dbg_pc == 16'hF800, "R3 pc", dbg_pc, 16'hF800);
    check(bus_valid && bus_rw && bus_addr == 16'hF800, "R3 bus", bus_addr, 16'hF800);
    check(!illegal, "R3 illegal", illegal, 0);
    check({dbg_a, dbg_b} == 16'h0000, "R3 d", {dbg_a, dbg_b}, 0);
    check(dbg_x == 16'h1234 && dbg_y == 16'h43BE, "R3 xy", {dbg_x, dbg_y}, 32'h123443BE);

    // program 1: load, store, add, add with wrap, store, load back, fault
    code_mem[8'h00] = 8'h96; code_mem[8'h01] = 8'h32;
    code_mem[8'h02] = 8'h18; code_mem[8'h03] = 8'hDF; code_mem[8'h04] = 8'h77;
    code_mem[8'h05] = 8'hD3; code_mem[8'h06] = 8'h10;
    code_mem[8'h07] = 8'h96; code_mem[8'h08] = 8'hFF;
    code_mem[8'h09] = 8'hD3; code_mem[8'h0A] = 8'hFF;
    code_mem[8'h0B] = 8'h18; code_mem[8'h0C] = 8'hDF; code_mem[8'h0D] = 8'hFF;
    code_mem[8'h0E] = 8'h96; code_mem[8'h0F] = 8'hFF;
    code_mem[8'h10] = 8'h42;
    page_mem[9'h032] = 8'h15;
    page_mem[9'h010] = 8'h00; page_mem[9'h011] = 8'hAE;
    page_mem[9'h0FF] = 8'h80; page_mem[9'h100] = 8'h90;

    start(16'hF800, 16'h0000, "R3 first fetch");
    rd(16'hF801, 16'hF801, "R4 dd fetch");
    rd(16'h0032, 16'hF802, "R4 R7 operand read");
    start(16'hF802, 16'h1500, "R4 R9 A loaded");
    rd(16'hF803, 16'hF803, "R5 R2 opcode after prefix");
    rd(16'hF804, 16'hF804, "R5 dd fetch");
    wr(16'h0077, 8'h43, 16'hF805, "R5 R1 high byte write");
    wr(16'h0078, 8'hBE, 16'hF805, "R5 R7 low byte write");
    start(16'hF805, 16'h1500, "R2 next after store");
    rd(16'hF806, 16'hF806, "R6 dd fetch");
    rd(16'h0010, 16'hF807, "R6 high read");
    rd(16'h0011, 16'hF807, "R6 low read");
    idle(16'hF807, 0, "R6 R12 internal cycle");
    start(16'hF807, 16'h15AE, "R6 sum");
    rd(16'hF808, 16'hF808, "R4 dd fetch");
    rd(16'h00FF, 16'hF809, "R4 read at ff");
    start(16'hF809, 16'h80AE, "R4 R9 A only");
    rd(16'hF80A, 16'hF80A, "R6 dd fetch");
    rd(16'h00FF, 16'hF80B, "R7 high at ff");
    rd(16'h0100, 16'hF80B, "R7 low crosses to 0100");
    idle(16'hF80B, 0, "R12 internal cycle");
    start(16'hF80B, 16'h013E, "R8 wrapped sum");
    rd(16'hF80C, 16'hF80C, "R5 opcode");
    rd(16'hF80D, 16'hF80D, "R5 dd");
    wr(16'h00FF, 8'h43, 16'hF80E, "R5 high at ff");
    wr(16'h0100, 8'hBE, 16'hF80E, "R5 R7 low at 0100");
    start(16'hF80E, 16'h013E, "R2 next after store");
    rd(16'hF80F, 16'hF80F, "R4 dd");
    rd(16'h00FF, 16'hF810, "R4 read back stored byte");
    start(16'hF810, 16'h433E, "R4 loaded stored byte");
    idle(16'hF810, 1, "R10 halted");
    idle(16'hF810, 1, "R10 halted");
    idle(16'hF810, 1, "R10 R12 halted");
    run_queue();

    check(page_mem[9'h077] == 8'h43 && page_mem[9'h078] == 8'hBE, "R5 memory at 77",
          {page_mem[9'h077], page_mem[9'h078]}, 16'h43BE);
    check(page_mem[9'h0FF] == 8'h43 && page_mem[9'h100] == 8'hBE, "R5 memory at ff",
          {page_mem[9'h0FF], page_mem[9'h100]}, 16'h43BE);
    check(dbg_a == 8'h43 && dbg_b == 8'h3E, "R9 A B split", {dbg_a, dbg_b}, 16'h433E);
    check(illegal && !bus_valid && dbg_pc == 16'hF810, "R10 stays halted", {illegal, dbg_pc}, 17'h1F810);

    // program 2: bad byte after the prefix
    do_reset();
    clear_mem();
    code_mem[8'h00] = 8'h18; code_mem[8'h01] = 8'h55;
    start(16'hF800, 16'h0000, "R3 reset clears D and fault");
    rd(16'hF801, 16'hF801, "R11 second byte");
    idle(16'hF801, 1, "R11 halted");
    idle(16'hF801, 1, "R11 halted");
    run_queue();

    // program 3: store opcode without prefix is not valid
    do_reset();
    clear_mem();
    code_mem[8'h00] = 8'hDF;
    start(16'hF800, 16'h0000, "R10 fetch");
    idle(16'hF800, 1, "R10 halted at offending byte");
    idle(16'hF800, 1, "R10 halted");
    run_queue();
    check(dbg_x == 16'h1234 && dbg_y == 16'h43BE, "R3 xy kept", {dbg_x, dbg_y}, 32'h123443BE);

    summary();
    $finish;
  end

endmodule